// File: doc/BRIEF.md
# Dual-Context Configuration Bank with Masked Memory Moves

This block keeps the working configuration of a content-addressable memory in two full copies, a foreground set and a background set, and switches between them with one command. Each copy holds a control word, an address pointer, the first mask, the persistent segment source and destination codes, and the two segment counters. The comparand and the second mask exist only once. A filtering set and a purging set can therefore be pre-loaded and swapped in a single cycle. A swap also drops the stored match result.

The block also builds every memory write. A move command takes its data from the comparand, the active first mask, the second mask, or the command bus. It sends that data to one of four addresses: the stored highest-priority match, the next-free address, an absolute address given with the command, or the active address pointer. The memory receives a per-bit write enable that is the inverse of the selected mask, so a mask bit of 1 keeps the stored bit. The address pointer can step up or down after each access through it. The second mask shifts by one bit per command. Wide registers are loaded and read 16 bits at a time through the segment counters. The memory array, the compare logic and the bus decoder sit outside the block.

Top module: `dcb_top`

## Requirements
- R1: After reset, active_set, match_vld, mem_we, seg_vld and cur_addr are 0, and both register sets are cleared.
- R2: Command SWAP (op 1) inverts active_set. The loads LD_CTRL (2), LD_ADDR (3), LD_MSK1 (5) and LD_PSD (10) and the pointer step change only the active set. The other set keeps its values until it is made active again.
- R3: SWAP clears match_vld in the same cycle that the set changes.
- R4: MOVE (op 9) drives mem_we high in the next cycle at an address chosen by mv_tgt: 0 = stored match address, 1 = nf_addr, 2 = abs_addr, 3 = active address pointer. mem_we is never high except in the cycle after a MOVE.
- R5: MOVE data is chosen by mv_src: 0 = comparand, 1 = active mask 1, 2 = mask 2, 3 = cmd_din.
- R6: Bits [3:2] of the active control word select the write mask: 1 gives mem_wbe = ~mask1, 2 gives mem_wbe = ~mask2, and 0 or 3 gives all ones. A 0 in mem_wbe means the memory bit is kept.
- R7: A MOVE to target 0 while match_vld is 0, or to target 1 while nf_valid is 0, produces no write.
- R8: When control bit 0 is 1, a MOVE to target 3 steps the active pointer after the access. Control bit 1 = 0 increments and 1 decrements, wrapping modulo 2^AW.
- R9: SHL_M2 (op 7) and SHR_M2 (op 8) shift mask 2 by one bit, filling with 0.
- R10: LD_PSD loads the destination code from cmd_din[1:0] and the source code from cmd_din[3:2] (0 = comparand, 1 = mask 1, 2 = mask 2, 3 = none) and clears both counters. Each SEG_WR (op 11) writes cmd_din[15:0] into the destination segment given by the write counter, lowest segment first, and then advances the counter with wrap.
- R11: Each SEG_RD (op 12) gives the source segment chosen by the read counter on seg_data, with seg_vld high, in the next cycle, and then advances the counter with wrap.
- R12: A cmp_done pulse stores cmp_hit as match_vld and cmp_addr as the match address, unless SWAP is in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_din | input | DW | Command data |
| mv_src | input | 2 | Move source select |
| mv_tgt | input | 2 | Move target select |
| abs_addr | input | AW | Absolute move address |
| cmp_done | input | 1 | Compare result strobe |
| cmp_hit | input | 1 | Compare found a match |
| cmp_addr | input | AW | Highest-priority match address |
| nf_valid | input | 1 | A free location exists |
| nf_addr | input | AW | Next free address |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_wbe | output | DW | Per-bit write enable |
| seg_vld | output | 1 | Segment read valid |
| seg_data | output | SW | Segment read data |
| active_set | output | 1 | Index of the active register set |
| match_vld | output | 1 | Stored match is valid |
| cur_addr | output | AW | Active address pointer |
| cmp_word | output | DW | Comparand to the compare logic |
| cmp_mask | output | DW | Active mask 1 to the compare logic |

## Verification
The assertions assume at most one command per cycle, with the cmd_op value held steady while cmd_valid is high. They also assume that cmp_done comes from the external compare logic as a single-cycle pulse. The bench meets these assumptions by issuing every command and every compare result as a one-cycle strobe from a task driven on the falling edge. It inserts an idle cycle after each strobe and reads the registered outputs on the following falling edge.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SWAP    = 4'd1,
    OP_LD_CTRL = 4'd2,
    OP_LD_ADDR = 4'd3,
    OP_LD_CMP  = 4'd4,
    OP_LD_MSK1 = 4'd5,
    OP_LD_MSK2 = 4'd6,
    OP_SHL_M2  = 4'd7,
    OP_SHR_M2  = 4'd8,
    OP_MOVE    = 4'd9,
    OP_LD_PSD  = 4'd10,
    OP_SEG_WR  = 4'd11,
    OP_SEG_RD  = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    SRC_CMP  = 2'd0,
    SRC_MSK1 = 2'd1,
    SRC_MSK2 = 2'd2,
    SRC_BUS  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    TGT_HPM   = 2'd0,
    TGT_NFREE = 2'd1,
    TGT_ABS   = 2'd2,
    TGT_AREG  = 2'd3
  } tgt_e;

  localparam int CTRL_W  = 4;
  localparam int CB_STEP = 0;
  localparam int CB_DOWN = 1;
  localparam int CB_WM   = 2;
endpackage

// File: rtl/dcb_ctx_bank.sv
module dcb_ctx_bank
  import dcb_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int SCW = 1,
  parameter int NSEG = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  op_e                 op,
  input  tgt_e                tgt,
  input  logic [DW-1:0]       din,
  input  logic [DW-1:0]       seg_new,
  output logic                active,
  output logic [CTRL_W-1:0]   ctrl,
  output logic [AW-1:0]       addr,
  output logic [DW-1:0]       mask1,
  output logic [1:0]          psrc,
  output logic [1:0]          pdst,
  output logic [SCW-1:0]      segw,
  output logic [SCW-1:0]      segr
);
  localparam int NCTX = 2;
  localparam logic [SCW-1:0] SEG_LAST = SCW'(NSEG - 1);
  localparam logic [AW-1:0]  A_ONE    = AW'(1);

  logic                active_q;
  logic [CTRL_W-1:0]   ctrl_all [NCTX];
  logic [AW-1:0]       addr_all [NCTX];
  logic [DW-1:0]       m1_all   [NCTX];
  logic [1:0]          psrc_all [NCTX];
  logic [1:0]          pdst_all [NCTX];
  logic [SCW-1:0]      segw_all [NCTX];
  logic [SCW-1:0]      segr_all [NCTX];

  always_ff @(posedge clk) begin
    if (rst)
      active_q <= 1'b0;
    else if (cmd_valid && op == OP_SWAP)
      active_q <= ~active_q;
  end

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    logic [CTRL_W-1:0] ctrl_r;
    logic [AW-1:0]     addr_r;
    logic [DW-1:0]     m1_r;
    logic [1:0]        psrc_r;
    logic [1:0]        pdst_r;
    logic [SCW-1:0]    segw_r;
    logic [SCW-1:0]    segr_r;
    logic              mine;

    assign mine = cmd_valid && (active_q == 1'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_r <= '0;
        addr_r <= '0;
        m1_r   <= '0;
        psrc_r <= '0;
        pdst_r <= '0;
        segw_r <= '0;
        segr_r <= '0;
      end else if (mine) begin
        case (op)
          OP_LD_CTRL: ctrl_r <= din[CTRL_W-1:0];
          OP_LD_ADDR: addr_r <= din[AW-1:0];
          OP_LD_MSK1: m1_r   <= din;
          OP_LD_PSD: begin
            pdst_r <= din[1:0];
            psrc_r <= din[3:2];
            segw_r <= '0;
            segr_r <= '0;
          end
          OP_SEG_WR: begin
            segw_r <= (segw_r == SEG_LAST) ? '0 : segw_r + SCW'(1);
            if (pdst_r == SRC_MSK1) m1_r <= seg_new;
          end
          OP_SEG_RD:
            segr_r <= (segr_r == SEG_LAST) ? '0 : segr_r + SCW'(1);
          OP_MOVE:
            if (tgt == TGT_AREG && ctrl_r[CB_STEP])
              addr_r <= ctrl_r[CB_DOWN] ? addr_r - A_ONE : addr_r + A_ONE;
          default: ;
        endcase
      end
    end

    assign ctrl_all[g] = ctrl_r;
    assign addr_all[g] = addr_r;
    assign m1_all[g]   = m1_r;
    assign psrc_all[g] = psrc_r;
    assign pdst_all[g] = pdst_r;
    assign segw_all[g] = segw_r;
    assign segr_all[g] = segr_r;
  end

  assign active = active_q;
  assign ctrl   = ctrl_all[active_q];
  assign addr   = addr_all[active_q];
  assign mask1  = m1_all[active_q];
  assign psrc   = psrc_all[active_q];
  assign pdst   = pdst_all[active_q];
  assign segw   = segw_all[active_q];
  assign segr   = segr_all[active_q];

  p_swap_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_SWAP) |=> (active_q != $past(active_q)));

  p_hold_set_r2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && op == OP_SWAP) |=> (active_q == $past(active_q)));

  p_step_up_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_MOVE && tgt == TGT_AREG && ctrl[CB_STEP] && !ctrl[CB_DOWN])
      |=> (addr == $past(addr) + A_ONE));

  p_step_down_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_MOVE && tgt == TGT_AREG && ctrl[CB_STEP] && ctrl[CB_DOWN])
      |=> (addr == $past(addr) - A_ONE));
endmodule

// File: rtl/dcb_mask2.sv
module dcb_mask2
  import dcb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          shl,
  input  logic          shr,
  input  logic          seg_ld,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] seg_new,
  output logic [DW-1:0] m2
);
  logic [DW-1:0] m2_q;

  always_ff @(posedge clk) begin
    if (rst)
      m2_q <= '0;
    else if (ld)
      m2_q <= din;
    else if (shl)
      m2_q <= {m2_q[DW-2:0], 1'b0};
    else if (shr)
      m2_q <= {1'b0, m2_q[DW-1:1]};
    else if (seg_ld)
      m2_q <= seg_new;
  end

  assign m2 = m2_q;

  p_shift_left_r9: assert property (@(posedge clk) disable iff (rst)
    (shl && !ld) |=> (m2_q[DW-1:1] == $past(m2_q[DW-2:0]) && !m2_q[0]));

  p_shift_right_r9: assert property (@(posedge clk) disable iff (rst)
    (shr && !ld && !shl) |=> (m2_q[DW-2:0] == $past(m2_q[DW-1:1]) && !m2_q[DW-1]));
endmodule

// File: rtl/dcb_wpath.sv
module dcb_wpath
  import dcb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mv,
  input  src_e          src,
  input  tgt_e          tgt,
  input  logic [1:0]    wmsel,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] comparand,
  input  logic [DW-1:0] mask1,
  input  logic [DW-1:0] mask2,
  input  logic [AW-1:0] abs_addr,
  input  logic [AW-1:0] areg,
  input  logic          hpm_vld,
  input  logic [AW-1:0] hpm_addr,
  input  logic          nf_ok,
  input  logic [AW-1:0] nf_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_wbe
);
  logic [AW-1:0] t_addr;
  logic [DW-1:0] t_data;
  logic [DW-1:0] t_wbe;
  logic          blocked;
  logic          go;

  always_comb begin
    case (tgt)
      TGT_HPM:   t_addr = hpm_addr;
      TGT_NFREE: t_addr = nf_addr;
      TGT_ABS:   t_addr = abs_addr;
      default:   t_addr = areg;
    endcase
    case (src)
      SRC_CMP:  t_data = comparand;
      SRC_MSK1: t_data = mask1;
      SRC_MSK2: t_data = mask2;
      default:  t_data = din;
    endcase
    case (wmsel)
      2'd1:    t_wbe = ~mask1;
      2'd2:    t_wbe = ~mask2;
      default: t_wbe = '1;
    endcase
    blocked = (tgt == TGT_HPM && !hpm_vld) || (tgt == TGT_NFREE && !nf_ok);
    go      = mv && !blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wbe   <= '0;
    end else begin
      mem_we <= go;
      if (go) begin
        mem_addr  <= t_addr;
        mem_wdata <= t_data;
        mem_wbe   <= t_wbe;
      end
    end
  end

  p_we_cause_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mv));

  p_hpm_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (mv && tgt == TGT_HPM && !hpm_vld) |=> !mem_we);

  p_nf_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (mv && tgt == TGT_NFREE && !nf_ok) |=> !mem_we);
endmodule

// File: rtl/dcb_top.sv
module dcb_top
  import dcb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [DW-1:0] cmd_din,
  input  logic [1:0]    mv_src,
  input  logic [1:0]    mv_tgt,
  input  logic [AW-1:0] abs_addr,
  input  logic          cmp_done,
  input  logic          cmp_hit,
  input  logic [AW-1:0] cmp_addr,
  input  logic          nf_valid,
  input  logic [AW-1:0] nf_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_wbe,
  output logic          seg_vld,
  output logic [SW-1:0] seg_data,
  output logic          active_set,
  output logic          match_vld,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cmp_word,
  output logic [DW-1:0] cmp_mask
);
  localparam int NSEG = DW / SW;
  localparam int SCW  = (NSEG > 1) ? $clog2(NSEG) : 1;

  op_e  op;
  src_e src;
  tgt_e tgt;
  assign op  = op_e'(cmd_op);
  assign src = src_e'(mv_src);
  assign tgt = tgt_e'(mv_tgt);

  logic [CTRL_W-1:0] ctrl;
  logic [AW-1:0]     areg;
  logic [DW-1:0]     mask1;
  logic [DW-1:0]     mask2;
  logic [1:0]        psrc;
  logic [1:0]        pdst;
  logic [SCW-1:0]    segw;
  logic [SCW-1:0]    segr;
  logic [DW-1:0]     cmp_q;
  logic              hpm_vld_q;
  logic [AW-1:0]     hpm_addr_q;
  logic [DW-1:0]     dst_val;
  logic [DW-1:0]     src_val;
  logic [DW-1:0]     seg_new;
  logic [SW-1:0]     seg_pick;
  logic              swap;
  logic              seg_wr;

  assign swap   = cmd_valid && op == OP_SWAP;
  assign seg_wr = cmd_valid && op == OP_SEG_WR;

  dcb_ctx_bank #(.DW(DW), .AW(AW), .SCW(SCW), .NSEG(NSEG)) u_bank (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op), .tgt(tgt),
    .din(cmd_din), .seg_new(seg_new), .active(active_set), .ctrl(ctrl),
    .addr(areg), .mask1(mask1), .psrc(psrc), .pdst(pdst),
    .segw(segw), .segr(segr)
  );

  dcb_mask2 #(.DW(DW)) u_m2 (
    .clk(clk), .rst(rst),
    .ld(cmd_valid && op == OP_LD_MSK2),
    .shl(cmd_valid && op == OP_SHL_M2),
    .shr(cmd_valid && op == OP_SHR_M2),
    .seg_ld(seg_wr && pdst == SRC_MSK2),
    .din(cmd_din), .seg_new(seg_new), .m2(mask2)
  );

  dcb_wpath #(.DW(DW), .AW(AW)) u_wp (
    .clk(clk), .rst(rst), .mv(cmd_valid && op == OP_MOVE), .src(src),
    .tgt(tgt), .wmsel(ctrl[CB_WM +: 2]), .din(cmd_din), .comparand(cmp_q),
    .mask1(mask1), .mask2(mask2), .abs_addr(abs_addr), .areg(areg),
    .hpm_vld(hpm_vld_q), .hpm_addr(hpm_addr_q), .nf_ok(nf_valid),
    .nf_addr(nf_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wbe(mem_wbe)
  );

  always_comb begin
    case (pdst)
      2'd0:    dst_val = cmp_q;
      2'd1:    dst_val = mask1;
      2'd2:    dst_val = mask2;
      default: dst_val = '0;
    endcase
    case (psrc)
      2'd0:    src_val = cmp_q;
      2'd1:    src_val = mask1;
      2'd2:    src_val = mask2;
      default: src_val = '0;
    endcase
    seg_new  = dst_val;
    seg_pick = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (segw == SCW'(s)) seg_new[s*SW +: SW] = cmd_din[SW-1:0];
      if (segr == SCW'(s)) seg_pick = src_val[s*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q      <= '0;
      hpm_vld_q  <= 1'b0;
      hpm_addr_q <= '0;
      seg_vld    <= 1'b0;
      seg_data   <= '0;
    end else begin
      if (cmd_valid && op == OP_LD_CMP)
        cmp_q <= cmd_din;
      else if (seg_wr && pdst == SRC_CMP)
        cmp_q <= seg_new;
      if (swap) begin
        hpm_vld_q <= 1'b0;
      end else if (cmp_done) begin
        hpm_vld_q  <= cmp_hit;
        hpm_addr_q <= cmp_addr;
      end
      seg_vld <= cmd_valid && op == OP_SEG_RD;
      if (cmd_valid && op == OP_SEG_RD) seg_data <= seg_pick;
    end
  end

  assign match_vld = hpm_vld_q;
  assign cur_addr  = areg;
  assign cmp_word  = cmp_q;
  assign cmp_mask  = mask1;

  p_swap_clear_r3: assert property (@(posedge clk) disable iff (rst)
    swap |=> !match_vld);

  p_cmp_latch_r12: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && !swap) |=> (match_vld == $past(cmp_hit)));

  p_seg_vld_r11: assert property (@(posedge clk) disable iff (rst)
    seg_vld |-> $past(cmd_valid && op == OP_SEG_RD));
endmodule

// File: tb/dcb_top_bench.sv
module dcb_top_bench;
  import dcb_pkg::*;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic [DW-1:0] cmd_din = '0;
  logic [1:0]    mv_src = '0;
  logic [1:0]    mv_tgt = '0;
  logic [AW-1:0] abs_addr = 4'd12;
  logic          cmp_done = 1'b0;
  logic          cmp_hit = 1'b0;
  logic [AW-1:0] cmp_addr = '0;
  logic          nf_valid = 1'b1;
  logic [AW-1:0] nf_addr = 4'd9;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_wbe;
  logic          seg_vld;
  logic [SW-1:0] seg_data;
  logic          active_set;
  logic          match_vld;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cmp_word;
  logic [DW-1:0] cmp_mask;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dcb_top #(.DW(DW), .AW(AW), .SW(SW)) u_dcb_top (.*);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [DW-1:0] d,
                       input logic [1:0] s, input logic [1:0] t);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_din = d; mv_src = s; mv_tgt = t;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = OP_NOP;
  endtask

  task automatic cmp_res(input logic hit, input logic [AW-1:0] a);
    @(negedge clk);
    cmp_done = 1'b1; cmp_hit = hit; cmp_addr = a;
    @(negedge clk);
    cmp_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [DW-1:0] C  = 32'h1234_5678;
  localparam logic [DW-1:0] M1 = 32'h00FF_00F0;
  localparam logic [DW-1:0] M2 = 32'h0F0F_0000;
  localparam logic [DW-1:0] D  = 32'hCAFE_BABE;
  localparam logic [DW-1:0] X  = 32'hFFFF_0000;

  initial begin
    logic [AW-1:0] ea;
    logic [DW-1:0] ed, ew, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {91'd0, active_set, match_vld, mem_we, seg_vld, 1'b0}, 96'd0);
    chk("R1 addr", {92'd0, cur_addr}, 96'd0);

    issue(OP_LD_CMP, C, 0, 0);
    issue(OP_LD_MSK1, M1, 0, 0);
    issue(OP_LD_MSK2, M2, 0, 0);
    issue(OP_LD_ADDR, 32'd3, 0, 0);
    cmp_res(1'b1, 4'd5);
    chk("R12 hit", {95'd0, match_vld}, 96'd1);

    // R4 R5 R6 sweep over mask select, source, target
    for (int wm = 0; wm < 3; wm++) begin
      issue(OP_LD_CTRL, 32'(wm << 2), 0, 0);
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 4; t++) begin
          issue(OP_MOVE, D, 2'(s), 2'(t));
          ea = (t == 0) ? 4'd5 : (t == 1) ? 4'd9 : (t == 2) ? 4'd12 : 4'd3;
          ed = (s == 0) ? C : (s == 1) ? M1 : (s == 2) ? M2 : D;
          ew = (wm == 1) ? ~M1 : (wm == 2) ? ~M2 : '1;
          chk("R4 R5 R6 move", {27'd0, mem_we, ea, ed, ew}, {27'd0, 1'b1, mem_addr, mem_wdata, mem_wbe});
        end
      end
    end

    // R2 R3 swap
    issue(OP_SWAP, 0, 0, 0);
    chk("R2 swap", {95'd0, active_set}, 96'd1);
    chk("R3 clear", {95'd0, match_vld}, 96'd0);
    // R7 suppression
    issue(OP_MOVE, D, 3, 0);
    chk("R7 hpm", {95'd0, mem_we}, 96'd0);
    nf_valid = 1'b0;
    issue(OP_MOVE, D, 3, 1);
    chk("R7 nf", {95'd0, mem_we}, 96'd0);
    issue(OP_MOVE, D, 3, 2);
    chk("R7 abs ok", {63'd0, mem_we, mem_wdata}, {63'd0, 1'b1, D});
    nf_valid = 1'b1;

    // R2 independence of the two sets
    issue(OP_LD_ADDR, 32'd7, 0, 0);
    issue(OP_LD_MSK1, X, 0, 0);
    issue(OP_SWAP, 0, 0, 0);
    chk("R2 set0 addr", {91'd0, active_set, cur_addr}, {91'd0, 1'b0, 4'd3});
    issue(OP_MOVE, 0, 1, 2);
    chk("R2 set0 mask", {mem_wdata, mem_wbe}, {M1, ~M2});
    issue(OP_SWAP, 0, 0, 0);
    chk("R2 set1 addr", {91'd0, active_set, cur_addr}, {91'd0, 1'b1, 4'd7});
    issue(OP_MOVE, 0, 1, 2);
    chk("R2 set1 mask", {mem_wdata, mem_wbe}, {X, 32'hFFFF_FFFF});

    // R8 stepping with wrap
    issue(OP_LD_CTRL, 32'd1, 0, 0);
    issue(OP_LD_ADDR, 32'd14, 0, 0);
    for (int i = 0; i < 4; i++) begin
      issue(OP_MOVE, D, 3, 3);
      chk("R8 inc", {91'd0, mem_we, mem_addr}, {91'd0, 1'b1, 4'(14 + i)});
    end
    chk("R8 inc ptr", {92'd0, cur_addr}, 96'd2);
    issue(OP_LD_CTRL, 32'd3, 0, 0);
    for (int i = 0; i < 3; i++) begin
      issue(OP_MOVE, D, 3, 3);
      chk("R8 dec", {92'd0, mem_addr}, {92'd0, 4'(2 - i)});
    end
    chk("R8 dec wrap", {92'd0, cur_addr}, 96'd15);
    issue(OP_LD_CTRL, 32'd0, 0, 0);

    // R9 shifts
    v = 32'hC000_0003;
    issue(OP_LD_MSK2, v, 0, 0);
    for (int i = 0; i < 8; i++) begin
      if (i % 3 == 2) begin
        issue(OP_SHR_M2, 0, 0, 0);
        v = v >> 1;
      end else begin
        issue(OP_SHL_M2, 0, 0, 0);
        v = v << 1;
      end
      issue(OP_MOVE, 0, 2, 2);
      chk("R9 shift", {64'd0, mem_wdata}, {64'd0, v});
    end

    // R10 segment writes into comparand, source mask 2
    issue(OP_LD_PSD, 32'h8, 0, 0);
    issue(OP_SEG_WR, 32'hAAAA, 0, 0);
    issue(OP_SEG_WR, 32'hBBBB, 0, 0);
    chk("R10 seg wr", {64'd0, cmp_word}, {64'd0, 32'hBBBB_AAAA});
    issue(OP_SEG_WR, 32'hCCCC, 0, 0);
    chk("R10 seg wrap", {64'd0, cmp_word}, {64'd0, 32'hBBBB_CCCC});
    // R11 segment reads
    issue(OP_SEG_RD, 0, 0, 0);
    chk("R11 seg0", {79'd0, seg_vld, seg_data}, {79'd0, 1'b1, v[15:0]});
    issue(OP_SEG_RD, 0, 0, 0);
    chk("R11 seg1", {79'd0, seg_vld, seg_data}, {79'd0, 1'b1, v[31:16]});
    issue(OP_SEG_RD, 0, 0, 0);
    chk("R11 wrap", {80'd0, seg_data}, {80'd0, v[15:0]});
    // R10 destination mask 1, source comparand, counters reset
    issue(OP_LD_PSD, 32'h1, 0, 0);
    issue(OP_SEG_WR, 32'h1111, 0, 0);
    chk("R10 mask1", {64'd0, cmp_mask}, {64'd0, 32'hFFFF_1111});
    issue(OP_SEG_RD, 0, 0, 0);
    chk("R11 reset ctr", {80'd0, seg_data}, {80'd0, 16'hCCCC});

    // R12 match latch
    cmp_res(1'b1, 4'd10);
    issue(OP_MOVE, D, 3, 0);
    chk("R12 hpm addr", {91'd0, mem_we, mem_addr}, {91'd0, 1'b1, 4'd10});
    cmp_res(1'b0, 4'd2);
    chk("R12 miss", {95'd0, match_vld}, 96'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule